// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two signed operands and adds the product into a double-width accumulator. The accumulator is held as a high word and a low word. Each accepted operation completes in the clock edge that accepts it. The unit offers two multiply modes. Long mode multiplies the full operands. Word mode multiplies only the sign-extended lower halves. A saturation-enable input selects a clamp, and each mode applies its own rule.

Operations arrive on a valid/ready handshake. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low in any cycle where a clear or a load is requested, because those take the accumulator in that cycle. An operation offered in such a cycle is not accepted, and the source must hold it until `in_ready` returns. The result appears on `acc_hi`/`acc_lo` after the accepting edge, and `out_valid` pulses high for exactly that one cycle. The output side has no back-pressure: the accumulator words are always readable.

Top module: `mac_sat_acc`

## Requirements
- R1: After reset, both accumulator words are zero and `out_valid` is low.
- R2: When `clr` is high at a rising edge, both accumulator words become zero. This takes priority over `ld` and over any offered operation.
- R3: When `ld` is high and `clr` is low at a rising edge, the accumulator takes `ld_hi` as its high word and `ld_lo` as its low word.
- R4: In long mode (`op_word`=0) with `sat_en` low, the full signed product of `opnd_a` and `opnd_b` is added to the accumulator. The accumulator is read as a signed 2W-bit value, and the sum wraps modulo 2^(2W).
- R5: In word mode (`op_word`=1) with `sat_en` low, the product uses only bits [W/2-1:0] of each operand, read as signed. The upper operand bits have no effect. The sum wraps as in R4.
- R6: In long mode with `sat_en` high, if the wrapped sum is negative, the top W/2 bits of the high word are forced to one. If the wrapped sum is zero or positive, all high-word bits above bit W/2-2 are forced to zero. The low word is unchanged.
- R7: In word mode with `sat_en` high, if the wrapped sum is below -2^(W-1), the high word becomes 1 and the low word becomes 2^(W-1) (only the sign bit set).
- R8: In word mode with `sat_en` high, if the wrapped sum is above 2^(W-1)-1, the high word becomes 1 and the low word becomes 2^(W-1)-1. A sum inside that range is stored unchanged.
- R9: `out_valid` is high for exactly the one cycle that follows an accepting edge. It stays low after clears, after loads and after idle cycles. With nothing accepted, cleared or loaded, the accumulator holds its value.
- R10: `in_ready` is low exactly when `clr` or `ld` is high. An operation offered while `in_ready` is low leaves the accumulator as the clear or load sets it, and raises no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Zero both accumulator words |
| ld | input | 1 | Preset the accumulator from `ld_hi`/`ld_lo` |
| ld_hi | input | W | High word preset value |
| ld_lo | input | W | Low word preset value |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op_word | input | 1 | 0 = long mode, 1 = word mode |
| sat_en | input | 1 | Enable the mode's saturation rule |
| opnd_a | input | W | First signed operand |
| opnd_b | input | W | Second signed operand |
| out_valid | output | 1 | One-cycle pulse after an accepted operation |
| acc_hi | output | W | Accumulator high word |
| acc_lo | output | W | Accumulator low word |

## Verification
The bench builds the unit with W=8, so the accumulator is 16 bits wide and word mode multiplies 4-bit halves. At that width, word mode can be swept over every pair of operand halves, starting from several preset accumulators that sit on either side of the clamp thresholds. Long mode is swept over every value of one operand against a strided set of the other. The sum is left to wrap, so it crosses the sign boundary many times and exercises both long-mode saturation branches. Reference results are computed with integer arithmetic in the bench.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_prod.sv
module mac_prod
  import mac_sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  mac_mode_e      mode,
  output logic [2*W-1:0] prod
);
  localparam int HALF = W / 2;
  localparam int AW   = 2 * W;

  logic signed [AW-1:0] a_long, b_long, a_half, b_half;
  logic signed [AW-1:0] ma, mb;

  // sign-extend either the whole operand or its lower half to accumulator width
  always_comb begin
    a_long = {{(AW-W){a[W-1]}}, a};
    b_long = {{(AW-W){b[W-1]}}, b};
    a_half = {{(AW-HALF){a[HALF-1]}}, a[HALF-1:0]};
    b_half = {{(AW-HALF){b[HALF-1]}}, b[HALF-1:0]};
    ma = (mode == MODE_WORD) ? a_half : a_long;
    mb = (mode == MODE_WORD) ? b_half : b_long;
  end

  // low AW bits of the signed product are exact for both modes
  assign prod = ma * mb;
endmodule

// File: rtl/mac_clamp.sv
module mac_clamp
  import mac_sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] sum,
  input  mac_mode_e      mode,
  input  logic           sat_en,
  output logic [2*W-1:0] res
);
  localparam int HALF = W / 2;
  localparam int KEEP = HALF - 1;
  localparam logic [W-1:0] UPPER_MASK = {{HALF{1'b1}}, {(W-HALF){1'b0}}};
  localparam logic [W-1:0] KEEP_MASK  = {{(W-KEEP){1'b0}}, {KEEP{1'b1}}};
  localparam logic [W-1:0] LO_MIN     = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LO_MAX     = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] HI_MARK    = W'(1);

  logic [W:0]   top_bits;
  logic         fits_word;
  logic         neg;
  logic [W-1:0] hi, lo;

  assign top_bits  = sum[2*W-1:W-1];
  assign fits_word = (&top_bits) | ~(|top_bits);
  assign neg       = sum[2*W-1];

  always_comb begin
    hi = sum[2*W-1:W];
    lo = sum[W-1:0];
    if (sat_en) begin
      if (mode == MODE_LONG) begin
        hi = neg ? (hi | UPPER_MASK) : (hi & KEEP_MASK);
      end else if (!fits_word) begin
        hi = HI_MARK;
        lo = neg ? LO_MIN : LO_MAX;
      end
    end
    res = {hi, lo};
  end

  // clamp must never alter the low word in long mode
  always_comb begin
    if (sat_en && mode == MODE_LONG)
      AST_LONG_LO_KEPT: assert (res[W-1:0] == sum[W-1:0]); // R6
  end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ld,
  input  logic [W-1:0]   ld_hi,
  input  logic [W-1:0]   ld_lo,
  input  logic           upd,
  input  logic [2*W-1:0] nxt,
  output logic [2*W-1:0] acc,
  output logic           done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= upd & ~clr & ~ld;
      if (clr)      acc <= '0;
      else if (ld)  acc <= {ld_hi, ld_lo};
      else if (upd) acc <= nxt;
    end
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (acc == {$past(ld_hi), $past(ld_lo)})); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !upd) |=> ($stable(acc) && !done)); // R9
endmodule

// File: rtl/mac_sat_acc.sv
module mac_sat_acc
  import mac_sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_hi,
  input  logic [W-1:0] ld_lo,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         op_word,
  input  logic         sat_en,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo
);
  localparam int AW   = 2 * W;
  localparam int HALF = W / 2;

  mac_mode_e       mode;
  logic [AW-1:0]   prod, sum, clamped, acc;
  logic            accept;

  assign mode     = mac_mode_e'(op_word);
  assign in_ready = ~(clr | ld);
  assign accept   = in_valid & in_ready;

  mac_prod #(.W(W)) u_prod (
    .a(opnd_a), .b(opnd_b), .mode(mode), .prod(prod)
  );

  assign sum = acc + prod;

  mac_clamp #(.W(W)) u_clamp (
    .sum(sum), .mode(mode), .sat_en(sat_en), .res(clamped)
  );

  mac_acc_reg #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .upd(accept), .nxt(clamped), .acc(acc), .done(out_valid)
  );

  assign acc_hi = acc[AW-1:W];
  assign acc_lo = acc[W-1:0];

  AST_BLOCKED_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (clr || ld)) |=> !out_valid); // R10
  AST_LONG_SAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_en) && !$past(op_word) && acc_hi[W-1])
      |-> (&acc_hi[W-1:W-HALF])); // R6
  AST_LONG_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_en) && !$past(op_word) && !acc_hi[W-1])
      |-> (acc_hi[W-1:HALF-1] == '0)); // R6
  AST_WORD_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_en) && $past(op_word))
      |-> (acc_hi == '0 || (&acc_hi) || acc_hi == W'(1))); // R7
endmodule

// File: tb/sim_mac_sat_acc.sv
module sim_mac_sat_acc;
  localparam int W  = 8;
  localparam int AW = 2 * W;
  localparam int H  = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ld = 1'b0, in_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [W-1:0] ld_hi = '0, ld_lo = '0, opnd_a = '0, opnd_b = '0;
  logic in_ready, out_valid;
  logic [W-1:0] acc_hi, acc_lo;

  int tests = 0;
  int fails = 0;
  logic [AW-1:0] exp_acc = '0;

  always #2.5 clk = ~clk;

  mac_sat_acc #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .in_valid(in_valid), .in_ready(in_ready), .op_word(op_word), .sat_en(sat_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic chk(string req, logic [AW:0] act, logic [AW:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(logic [AW-1:0] acc, logic [W-1:0] a,
                                          logic [W-1:0] b, logic word, logic s);
    longint pa, pb, sm, lim;
    logic [AW-1:0] r;
    if (word) begin
      pa = longint'($signed(a[H-1:0]));
      pb = longint'($signed(b[H-1:0]));
    end else begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
    end
    sm = longint'($signed(acc)) + pa * pb;
    r = sm[AW-1:0];
    if (s && !word) begin
      if (r[AW-1]) begin
        for (int i = AW - H; i < AW; i++) r[i] = 1'b1;
      end else begin
        for (int i = W + H - 1; i < AW; i++) r[i] = 1'b0;
      end
    end else if (s && word) begin
      sm = longint'($signed(r));
      lim = longint'(1) <<< (W - 1);
      if (sm < -lim)        r = {W'(1), 1'b1, {(W-1){1'b0}}};
      else if (sm > lim - 1) r = {W'(1), 1'b0, {(W-1){1'b1}}};
    end
    return r;
  endfunction

  task automatic do_load(logic [W-1:0] hi, logic [W-1:0] lo);
    @(negedge clk);
    ld = 1'b1; ld_hi = hi; ld_lo = lo;
    @(negedge clk);
    ld = 1'b0;
    exp_acc = {hi, lo};
    chk("R3", {out_valid, acc_hi, acc_lo}, {1'b0, exp_acc});
  endtask

  task automatic do_op(string req, logic word, logic s, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_word = word; sat_en = s; opnd_a = a; opnd_b = b;
    exp_acc = model(exp_acc, a, b, word, s);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {out_valid, acc_hi, acc_lo}, {1'b1, exp_acc});
  endtask

  logic [AW-1:0] presets [8];

  initial begin
    presets[0] = 16'h0000; presets[1] = 16'h007C; presets[2] = 16'hFF83;
    presets[3] = 16'h0780; presets[4] = 16'hF87F; presets[5] = 16'h7FF0;
    presets[6] = 16'h8005; presets[7] = 16'h0100;

    repeat (3) @(negedge clk);
    chk("R1", {out_valid, acc_hi, acc_lo}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, acc_hi, acc_lo}, '0);

    // R3 load, R9 idle hold and no pulse
    do_load(8'h12, 8'h34);
    @(negedge clk);
    chk("R9", {out_valid, acc_hi, acc_lo}, {1'b0, exp_acc});

    // R4 simple long op, then R9 pulse lasts one cycle
    do_op("R4", 1'b0, 1'b0, 8'hFD, 8'h05);
    @(negedge clk);
    chk("R9", {out_valid, acc_hi, acc_lo}, {1'b0, exp_acc});

    // R10 op offered together with load: ready low, op ignored
    @(negedge clk);
    in_valid = 1'b1; opnd_a = 8'h7F; opnd_b = 8'h7F; op_word = 1'b0; sat_en = 1'b0;
    ld = 1'b1; ld_hi = 8'hA5; ld_lo = 8'h5A;
    #1 chk("R10", {16'h0, in_ready}, '0);
    @(negedge clk);
    ld = 1'b0; in_valid = 1'b0;
    exp_acc = 16'hA55A;
    chk("R10", {out_valid, acc_hi, acc_lo}, {1'b0, exp_acc});
    #1 chk("R10", {16'h0, in_ready}, 17'h1);

    // R2 clear beats load and op
    @(negedge clk);
    clr = 1'b1; ld = 1'b1; ld_hi = 8'h11; ld_lo = 8'h22; in_valid = 1'b1;
    @(negedge clk);
    clr = 1'b0; ld = 1'b0; in_valid = 1'b0;
    exp_acc = '0;
    chk("R2", {out_valid, acc_hi, acc_lo}, '0);

    // R5 upper operand bits ignored: word mode with noisy upper nibbles
    do_op("R5", 1'b1, 1'b0, 8'hA3, 8'h5D);
    do_op("R5", 1'b1, 1'b0, 8'h03, 8'hFD);

    // R7/R8 directed word clamps
    do_load(8'hFF, 8'h82);
    do_op("R7", 1'b1, 1'b1, 8'h07, 8'h08);
    chk("R7", {1'b0, acc_hi, acc_lo}, {1'b0, 16'h0180});
    do_load(8'h00, 8'h7A);
    do_op("R8", 1'b1, 1'b1, 8'h07, 8'h07);
    chk("R8", {1'b0, acc_hi, acc_lo}, {1'b0, 16'h017F});

    // R6 directed long clamps
    do_load(8'h40, 8'h00);
    do_op("R6", 1'b0, 1'b1, 8'h01, 8'h01);
    chk("R6", {1'b0, acc_hi, acc_lo}, {1'b0, 16'h0001});
    do_load(8'h80, 8'h00);
    do_op("R6", 1'b0, 1'b1, 8'h01, 8'h01);
    chk("R6", {1'b0, acc_hi, acc_lo}, {1'b0, 16'hF001});

    // word sweep: every pair of halves, every preset, both saturation settings
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            if (b == 0) do_load(presets[p][AW-1:W], presets[p][W-1:0]);
            do_op(s ? "R7_R8_word_sat" : "R5", 1'b1, s[0],
                  {4'(a ^ b), 4'(a)}, {4'(b + p), 4'(b)});
          end
        end
      end
    end

    // long sweep: every a, strided b, accumulating with periodic presets
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        if ((a % 16) == 0) do_load(presets[(a / 16) % 8][AW-1:W], presets[(a / 16) % 8][W-1:0]);
        for (int b = 0; b < 256; b += 9) begin
          do_op(s ? "R6" : "R4", 1'b0, s[0], 8'(a), 8'(b));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule